// File: doc/BRIEF.md
# Programmable Baud Divider With Latches

The block divides a reference clock by a 16-bit divisor. It produces a rate of sixteen times the intended baud rate for a serial receiver or transmitter. The divisor sits in two byte-wide latches, one for the low byte and one for the high byte. A narrow write port loads each latch on its own. Any latch write restarts the internal down-counter on the same edge. A newly programmed rate therefore takes effect at once and does not wait for a long count left over from the old divisor.

Two outputs are provided. `tick` is a one-cycle sample enable for synchronous logic, high in the first cycle of each divide period. `div_out` is a shaped waveform. For divisors of 3 and above it is low for the first two reference cycles of a period and high for the rest. A divisor of 2 gives a square wave at half the reference rate. A divisor of 0 behaves as a period of three. A divisor of 1 passes out the inverted reference clock. That last case is only meaningful when `clk` is the reference itself.

Top module: `baud_div_top`

## Requirements
- R1: `wr_sel` = 0 writes `wr_data` into the low divisor byte (bits 7:0), and `wr_sel` = 1 writes it into the high byte (bits 15:8). The other byte keeps its value, and the resulting 16-bit divisor sets the period in reference cycles.
- R2: While `rst` is high, both bytes clear to zero, `tick` is 0 and `div_out` is 1. The first cycle after reset is released is the first cycle of a period (`tick` = 1, `div_out` = 0).
- R3: In the cycle after any latch write, a new period begins with the new divisor: `tick` = 1 and, unless the divisor is 1, `div_out` = 0.
- R4: For a divisor N of 3 or more, `tick` is high exactly once every N cycles.
- R5: For a divisor N of 3 or more, `div_out` is low in the first two cycles of each period and high in the remaining N-2 cycles.
- R6: A divisor of 0 gives a period of 3 cycles: `div_out` is low for two cycles and high for one, with one `tick` per period.
- R7: A divisor of 2 makes `div_out` alternate every cycle, low in the `tick` cycle, and makes `tick` high every other cycle.
- R8: A divisor of 1 keeps `tick` high in every cycle and makes `div_out` the logical inverse of `clk`.
- R9: Except with a divisor of 1, `tick` is never high in two consecutive cycles unless a latch write falls between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Latch write strobe |
| wr_sel | input | 1 | Byte select: 0 low, 1 high |
| wr_data | input | 8 | Byte written into the selected latch |
| tick | output | 1 | One-cycle enable at the start of each period |
| div_out | output | 1 | Shaped divided waveform |

## Verification
A wrong count or reload value shows up as a `tick` early or late. This appears at the latest one period after the fault, and in the very first cycle after a write, because every write must start a period. A latch that corrupts the other byte, or ignores the high byte, only shows up once a whole period has run. For that reason the test spends a period of more than 256 cycles with the high byte set. A wrong shaping decode shows at `div_out` within the first three cycles of any period.

// File: rtl/brg_pkg.sv
package brg_pkg;
  // output shaping class picked from the active divisor
  typedef enum logic [1:0] {
    SHAPE_PULSE = 2'd0,  // low two cycles, then high
    SHAPE_HALF  = 2'd1,  // divide by two, even duty
    SHAPE_PASS  = 2'd2   // inverted reference clock
  } shape_e;

  localparam int unsigned ZERO_DIV_PERIOD = 3;
endpackage

// File: rtl/brg_latches.sv
module brg_latches #(
  parameter int DIV_W  = 16,
  parameter int BYTE_W = 8,
  parameter int SEL_W  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [DIV_W-1:0]  div_q,
  output logic [DIV_W-1:0]  div_d
);
  localparam int LANES = DIV_W / BYTE_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic              hit;
    logic [BYTE_W-1:0] lane_q;

    assign hit = wr_en && (wr_sel == SEL_W'(g));
    assign div_d[g*BYTE_W +: BYTE_W] = hit ? wr_data : lane_q;
    assign div_q[g*BYTE_W +: BYTE_W] = lane_q;

    always_ff @(posedge clk) begin
      if (rst) lane_q <= '0;
      else     lane_q <= div_d[g*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/brg_counter.sv
module brg_counter #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DIV_W-1:0] div_d,
  output logic [DIV_W-1:0] cnt_d,
  output logic [DIV_W-1:0] period_m1
);
  import brg_pkg::*;

  logic [DIV_W-1:0] cnt_q;

  // last index of a period; zero stands for a three-cycle period
  always_comb begin
    if (div_d == '0) period_m1 = DIV_W'(ZERO_DIV_PERIOD - 1);
    else             period_m1 = div_d - DIV_W'(1);
  end

  always_comb begin
    if (load || cnt_q == '0) cnt_d = period_m1;
    else                     cnt_d = cnt_q - DIV_W'(1);
  end

  // reset parks at the end of a period so the next edge opens one
  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end
endmodule

// File: rtl/brg_shaper.sv
module brg_shaper #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] cnt_d,
  input  logic [DIV_W-1:0] period_m1,
  input  logic [DIV_W-1:0] div_q,
  output logic             tick,
  output logic             div_out
);
  import brg_pkg::*;

  shape_e           shape_d;
  shape_e           shape_q;
  logic             tick_d;
  logic             wave_d;
  logic             tick_q;
  logic             wave_q;

  always_comb begin
    if (period_m1 == '0)           shape_d = SHAPE_PASS;
    else if (period_m1 == DIV_W'(1)) shape_d = SHAPE_HALF;
    else                           shape_d = SHAPE_PULSE;
  end

  assign tick_d = (cnt_d == period_m1);

  always_comb begin
    unique case (shape_d)
      SHAPE_PASS: wave_d = 1'b0;
      SHAPE_HALF: wave_d = (cnt_d == '0);
      default:    wave_d = (cnt_d < period_m1 - DIV_W'(1));
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q  <= 1'b0;
      wave_q  <= 1'b1;
      shape_q <= SHAPE_PULSE;
    end else begin
      tick_q  <= tick_d;
      wave_q  <= wave_d;
      shape_q <= shape_d;
    end
  end

  // divide-by-one follows the reference directly
  assign tick    = tick_q;
  assign div_out = (div_q == DIV_W'(1) && shape_q == SHAPE_PASS) ? ~clk : wave_q;
endmodule

// File: rtl/baud_div_top.sv
module baud_div_top #(
  parameter int DIV_W  = 16,
  parameter int BYTE_W = 8,
  parameter int SEL_W  = $clog2(DIV_W / BYTE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              tick,
  output logic              div_out
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_d;
  logic [DIV_W-1:0] cnt_d;
  logic [DIV_W-1:0] period_m1;

  brg_latches #(.DIV_W(DIV_W), .BYTE_W(BYTE_W), .SEL_W(SEL_W)) u_latch (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .div_q(div_q), .div_d(div_d)
  );

  brg_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk(clk), .rst(rst), .load(wr_en), .div_d(div_d),
    .cnt_d(cnt_d), .period_m1(period_m1)
  );

  brg_shaper #(.DIV_W(DIV_W)) u_shape (
    .clk(clk), .rst(rst), .cnt_d(cnt_d), .period_m1(period_m1),
    .div_q(div_q), .tick(tick), .div_out(div_out)
  );
endmodule

// File: rtl/brg_checker.sv
module brg_checker #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             tick,
  input logic             div_out,
  input logic [DIV_W-1:0] div_q
);
  // R2: reset state on the outputs
  p_reset_state_r2: assert property (@(posedge clk)
    rst |=> (!tick && div_out));

  // R3: every write opens a period
  p_restart_tick_r3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> tick);

  p_restart_low_r3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (div_q == DIV_W'(1) || !div_out));

  // R5: waveform low in the opening cycle of a period
  p_low_at_tick_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && div_q != DIV_W'(1)) |-> !div_out);

  // R7: divide by two toggles each cycle
  p_half_toggle_r7: assert property (@(posedge clk) disable iff (rst)
    (div_q == DIV_W'(2) && !wr_en) |=> (div_out != $past(div_out)));

  // R8: divide by one ticks every cycle
  p_pass_tick_r8: assert property (@(posedge clk) disable iff (rst)
    (div_q == DIV_W'(1)) |-> tick);

  // R9: one tick per period
  p_single_tick_r9: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_en && div_q != DIV_W'(1)) |=> !tick);
endmodule

bind baud_div_top brg_checker #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .tick(tick),
  .div_out(div_out), .div_q(div_q)
);

// File: tb/sim_baud_div_top.sv
module sim_baud_div_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [0:0] wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       tick;
  logic       div_out;

  baud_div_top u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .tick(tick), .div_out(div_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic  tick;
    logic  wave;
    string tag_t;
    string tag_w;
  } exp_t;

  exp_t sb[$];
  int   checks = 0;
  int   fails = 0;
  int   m_div = 0;
  int   m_pos = 0;
  bit   fresh = 1'b0;
  bit   release_pending = 1'b0;

  task automatic check(input string req, input logic act, input logic exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp_v, $time);
    end
  endtask

  // monitor: compare each cycle against the queued expectation
  always @(posedge clk) begin
    exp_t e;
    #2;
    if (sb.size() > 0) begin
      e = sb.pop_front();
      check(e.tag_t, tick, e.tick);
      check(e.tag_w, div_out, e.wave);
    end
  end

  // driver: one reference cycle, with an optional latch write
  task automatic step(input bit w, input bit s, input logic [7:0] d);
    exp_t e;
    int   period;
    @(negedge clk);
    #1;
    if (!rst && m_div == 1) check("R8", div_out, 1'b1);  // inverse of clk while low
    if (release_pending) begin
      rst = 1'b0;
      release_pending = 1'b0;
      fresh = 1'b1;
      m_div = 0;
    end
    wr_en = w; wr_sel = s; wr_data = d;
    period = (m_div == 0) ? 3 : m_div;
    if (w) begin
      if (s) m_div = (m_div & 32'h00FF) | (int'(d) << 8);
      else   m_div = (m_div & 32'hFF00) | int'(d);
      m_pos = 0;
    end else if (fresh) begin
      m_pos = 0;
    end else begin
      m_pos = (m_pos + 1) % period;
    end
    e.tick = (m_div == 1) || (m_pos == 0);
    e.wave = (m_div == 1) ? 1'b0 : (m_div == 2) ? (m_pos == 1) : (m_pos >= 2);
    e.tag_t = (m_div == 1) ? "R8" : (m_pos == 0) ? "R4" : "R9";
    e.tag_w = (m_div == 0) ? "R6" : (m_div == 1) ? "R8" : (m_div == 2) ? "R7" : "R5";
    if (w) begin e.tag_t = "R3"; e.tag_w = "R3"; end
    if (m_div > 255) begin e.tag_t = "R1"; e.tag_w = "R1"; end
    if (fresh) begin e.tag_t = "R2"; e.tag_w = "R2"; end
    fresh = 1'b0;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h00);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check("R2", tick, 1'b0);
    check("R2", div_out, 1'b1);
    release_pending = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    idle(10);                    // R6 from reset value zero
    step(1'b1, 1'b0, 8'd5);      // R3, R4, R5
    idle(12);
    step(1'b1, 1'b0, 8'd3);      // smallest pulse divisor
    idle(8);
    step(1'b1, 1'b0, 8'd2);      // R7
    idle(6);
    step(1'b1, 1'b0, 8'd1);      // R8
    idle(5);
    step(1'b1, 1'b1, 8'd1);      // R1: divisor 0x0101
    idle(520);
    step(1'b1, 1'b0, 8'd7);      // R1: low byte only, 0x0107
    idle(30);
    step(1'b1, 1'b1, 8'd0);      // back to 7
    idle(3);
    step(1'b1, 1'b0, 8'd4);      // R3: restart mid period
    idle(2);
    step(1'b1, 1'b0, 8'd6);      // R3: restart again before the end
    idle(10);
    step(1'b1, 1'b0, 8'd0);      // R6 by write
    idle(7);
    step(1'b1, 1'b0, 8'd9);
    idle(4);
    do_reset();                  // R2: latches cleared, period of three
    idle(10);
    @(posedge clk);
    #4;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule